// File: doc/BRIEF.md
# Table-Programmed Row Orchestrator

This block sequences one row of processing elements. Its behaviour is a finite-state machine whose states, transitions and per-state control words live in a table that is written before a kernel runs. Each state has four transition slots and one fallback slot. A transition slot holds an enable bit, a token source, a match value, a next-state index, a halt flag and an instruction word. The fallback slot holds a next state, a halt flag and an instruction.

At runtime the orchestrator takes metadata tokens, such as sparse coordinates, over a valid/ready port. It also samples a message value from a neighbouring element. On each running cycle it picks the lowest-numbered enabled slot whose match value equals the token from that slot's source. If no slot matches, it uses the fallback slot, but only when a metadata token is present. The chosen slot sets the next state and the control word issued to the row. With no usable token the state holds and a no-operation word is issued, so the row receives exactly one instruction on every running cycle.

A start pulse clears the state to 0 and begins a run. A slot with its halt flag set ends the run after issuing its instruction. The table can be written only while no run is in progress.

Top module: `row_orchestrator`

## Requirements
- R1: After reset the block is idle: `busy_o`=0, `instr_valid_o`=0, `state_o`=0, `meta_ready_o`=0. Every table entry is cleared, so each transition slot is disabled and each fallback slot holds next state 0, instruction 0 and no halt.
- R2: A write sets the entry at `cfg_addr_i` = {state[6:3], slot[2:0]}. Slots 0..3 are transitions and slot 4 is the fallback. Data bits are: [30] enable, [29] source (0 metadata, 1 neighbour message), [28] halt, [27:20] match, [19:16] next state, [15:0] instruction. The write takes effect only when `busy_o` is 0 at that edge; writes during a run and to slots 5..7 are ignored.
- R3: A start pulse makes `busy_o`=1, `state_o`=0 and `instr_valid_o`=0 after that edge, including when a run is already in progress. A start pulse overrides any token offered in the same cycle.
- R4: `meta_ready_o` is 1 exactly when a run is in progress and `start_i` is low. A metadata token is consumed only in such a cycle.
- R5: On a running cycle, an enabled metadata-source slot matches when `meta_valid_i` is 1 and `meta_data_i` equals its match field. At the next edge `state_o` takes the slot's next state, and `instr_o` takes its instruction with `instr_valid_o`=1.
- R6: When several slots match, the one with the lowest slot index is taken.
- R7: An enabled message-source slot matches when `msg_valid_i` is 1 and `msg_data_i` equals its match field, whether or not a metadata token is present.
- R8: When a metadata token is present and no slot matches, the fallback slot of the current state gives the next state and the instruction.
- R9: On a running cycle with no metadata token and no matching message slot, the state holds and `instr_valid_o`=1 with `instr_o`=0 (no-operation).
- R10: A taken slot with its halt flag set issues its instruction and then leaves the block idle. While idle, `instr_valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_addr_i | input | 7 | {state, slot} of the entry being written |
| cfg_data_i | input | 31 | Entry contents |
| start_i | input | 1 | Start pulse: state 0, begin run |
| meta_valid_i | input | 1 | Metadata token present |
| meta_data_i | input | 8 | Metadata token value |
| meta_ready_o | output | 1 | Token accepted this cycle if valid |
| msg_valid_i | input | 1 | Neighbour message present |
| msg_data_i | input | 8 | Neighbour message value |
| instr_o | output | 16 | Control word for the row |
| instr_valid_o | output | 1 | Control word issued this cycle |
| busy_o | output | 1 | Run in progress |
| state_o | output | 4 | Current state index |

## Verification
Two pairs of functions can coincide. A start pulse can land in the same cycle as a metadata token, and a table write can arrive while a run is in progress. The bench provokes both in directed steps and often during a long random phase. A cycle-accurate behavioural model in the bench judges each case: it expects the start to win and the token to be refused through `meta_ready_o`, and it expects a later token to follow the unchanged entry. A metadata match and a message match in the same state and cycle are also driven, to check that the lowest slot wins.

// File: rtl/row_orch_pkg.sv
`timescale 1ns/1ps
package row_orch_pkg;
  localparam int unsigned NUM_STATES_D = 16;
  localparam int unsigned TRANS_D      = 4;
  localparam int unsigned TOK_W_D      = 8;
  localparam int unsigned INSTR_W_D    = 16;

  typedef enum logic {
    SRC_META = 1'b0,
    SRC_MSG  = 1'b1
  } tok_src_e;
endpackage

// File: rtl/orch_cfg_table.sv
`timescale 1ns/1ps
module orch_cfg_table #(
  parameter int unsigned NUM_STATES = 16,
  parameter int unsigned SLOTS      = 5,
  parameter int unsigned ENT_W      = 31,
  parameter int unsigned STATE_W    = 4,
  parameter int unsigned SLOT_W     = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     busy_i,
  input  logic                     we_i,
  input  logic [STATE_W-1:0]       wstate_i,
  input  logic [SLOT_W-1:0]        wslot_i,
  input  logic [ENT_W-1:0]         wdata_i,
  input  logic [STATE_W-1:0]       rstate_i,
  output logic [SLOTS*ENT_W-1:0]   row_o
);
  localparam int unsigned DEPTH = NUM_STATES * SLOTS;
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [ENT_W-1:0]       mem_q [DEPTH];
  logic                   wr_ok;
  logic [IDX_W-1:0]       widx;
  logic [IDX_W-1:0]       rbase;
  logic [DEPTH*ENT_W-1:0] flat;

  assign wr_ok = we_i && !busy_i && (32'(wslot_i) < SLOTS) && (32'(wstate_i) < NUM_STATES);
  assign widx  = IDX_W'(wstate_i) * IDX_W'(SLOTS) + IDX_W'(wslot_i);
  assign rbase = IDX_W'(rstate_i) * IDX_W'(SLOTS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < int'(DEPTH); e++) mem_q[e] <= '0;
    end else if (wr_ok) begin
      mem_q[widx] <= wdata_i;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_rd
    assign row_o[s*ENT_W +: ENT_W] = mem_q[rbase + IDX_W'(s)];
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_flat
    assign flat[e*ENT_W +: ENT_W] = mem_q[e];
  end

  // table frozen while a run is in progress
  assert_table_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(flat));
endmodule

// File: rtl/orch_match.sv
`timescale 1ns/1ps
module orch_match
  import row_orch_pkg::*;
#(
  parameter int unsigned TRANS   = 4,
  parameter int unsigned TOK_W   = 8,
  parameter int unsigned STATE_W = 4,
  parameter int unsigned INSTR_W = 16,
  parameter int unsigned ENT_W   = 31
) (
  input  logic [(TRANS+1)*ENT_W-1:0] row_i,
  input  logic                       meta_valid_i,
  input  logic [TOK_W-1:0]           meta_i,
  input  logic                       msg_valid_i,
  input  logic [TOK_W-1:0]           msg_i,
  output logic                       take_o,
  output logic [STATE_W-1:0]         next_o,
  output logic [INSTR_W-1:0]         instr_o,
  output logic                       halt_o
);
  localparam int unsigned NEXT_LO  = INSTR_W;
  localparam int unsigned MATCH_LO = NEXT_LO + STATE_W;
  localparam int unsigned HALT_B   = MATCH_LO + TOK_W;
  localparam int unsigned SRC_B    = HALT_B + 1;
  localparam int unsigned EN_B     = SRC_B + 1;

  logic [ENT_W-1:0] ent [TRANS+1];
  logic [TRANS-1:0] hit;
  logic [TRANS-1:0] first;
  logic [TRANS:0]   seen;
  logic [ENT_W-1:0] sel;

  assign seen[0] = 1'b0;

  for (genvar t = 0; t <= TRANS; t++) begin : g_ent
    assign ent[t] = row_i[t*ENT_W +: ENT_W];
  end

  for (genvar t = 0; t < TRANS; t++) begin : g_hit
    logic [TOK_W-1:0] mval;
    logic             src_msg;
    assign mval    = ent[t][MATCH_LO +: TOK_W];
    assign src_msg = (tok_src_e'(ent[t][SRC_B]) == SRC_MSG);
    assign hit[t]  = ent[t][EN_B] &&
                     (src_msg ? (msg_valid_i && msg_i == mval)
                              : (meta_valid_i && meta_i == mval));
    assign seen[t+1] = seen[t] | hit[t];
    assign first[t]  = hit[t] & ~seen[t];
  end

  always_comb begin
    sel = ent[TRANS];
    for (int t = 0; t < int'(TRANS); t++) begin
      if (first[t]) sel = ent[t];
    end
  end

  assign take_o  = seen[TRANS] || meta_valid_i;
  assign next_o  = sel[NEXT_LO +: STATE_W];
  assign instr_o = sel[INSTR_W-1:0];
  assign halt_o  = sel[HALT_B];

  logic unused_sel;
  assign unused_sel = ^{sel[EN_B], sel[SRC_B], sel[MATCH_LO +: TOK_W]};
endmodule

// File: rtl/orch_seq.sv
`timescale 1ns/1ps
module orch_seq #(
  parameter int unsigned STATE_W = 4,
  parameter int unsigned INSTR_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               take_i,
  input  logic [STATE_W-1:0] next_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               halt_i,
  output logic               run_o,
  output logic [STATE_W-1:0] state_o,
  output logic [INSTR_W-1:0] instr_o,
  output logic               instr_valid_o
);
  logic               run_q, vld_q;
  logic [STATE_W-1:0] state_q;
  logic [INSTR_W-1:0] instr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      vld_q   <= 1'b0;
      state_q <= '0;
      instr_q <= '0;
    end else if (start_i) begin
      run_q   <= 1'b1;
      vld_q   <= 1'b0;
      state_q <= '0;
    end else if (run_q) begin
      vld_q <= 1'b1;
      if (take_i) begin
        state_q <= next_i;
        instr_q <= instr_i;
        if (halt_i) run_q <= 1'b0;
      end else begin
        instr_q <= '0;  // no-operation word
      end
    end else begin
      vld_q <= 1'b0;
    end
  end

  assign run_o         = run_q;
  assign state_o       = state_q;
  assign instr_o       = instr_q;
  assign instr_valid_o = vld_q;

  assert_start_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> run_q && state_q == '0 && !vld_q);
  assert_nop_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !start_i && !take_i |=> vld_q && instr_q == '0 && $stable(state_q));
  assert_halt_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !start_i && take_i && halt_i |=> !run_q && vld_q);
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !start_i |=> !vld_q && !run_q);
endmodule

// File: rtl/row_orchestrator.sv
`timescale 1ns/1ps
module row_orchestrator
  import row_orch_pkg::*;
#(
  parameter int unsigned NUM_STATES = NUM_STATES_D,
  parameter int unsigned TRANS      = TRANS_D,
  parameter int unsigned TOK_W      = TOK_W_D,
  parameter int unsigned INSTR_W    = INSTR_W_D,
  localparam int unsigned STATE_W   = $clog2(NUM_STATES),
  localparam int unsigned SLOTS     = TRANS + 1,
  localparam int unsigned SLOT_W    = $clog2(SLOTS),
  localparam int unsigned ADDR_W    = STATE_W + SLOT_W,
  localparam int unsigned ENT_W     = INSTR_W + STATE_W + TOK_W + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [ENT_W-1:0]   cfg_data_i,
  input  logic               start_i,
  input  logic               meta_valid_i,
  input  logic [TOK_W-1:0]   meta_data_i,
  output logic               meta_ready_o,
  input  logic               msg_valid_i,
  input  logic [TOK_W-1:0]   msg_data_i,
  output logic [INSTR_W-1:0] instr_o,
  output logic               instr_valid_o,
  output logic               busy_o,
  output logic [STATE_W-1:0] state_o
);
  logic                   run;
  logic [STATE_W-1:0]     cur_state;
  logic [SLOTS*ENT_W-1:0] row;
  logic                   take, halt;
  logic [STATE_W-1:0]     nxt;
  logic [INSTR_W-1:0]     ins;

  assign meta_ready_o = run && !start_i;

  orch_cfg_table #(
    .NUM_STATES(NUM_STATES), .SLOTS(SLOTS), .ENT_W(ENT_W),
    .STATE_W(STATE_W), .SLOT_W(SLOT_W)
  ) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (run),
    .we_i    (cfg_we_i),
    .wstate_i(cfg_addr_i[ADDR_W-1:SLOT_W]),
    .wslot_i (cfg_addr_i[SLOT_W-1:0]),
    .wdata_i (cfg_data_i),
    .rstate_i(cur_state),
    .row_o   (row)
  );

  orch_match #(
    .TRANS(TRANS), .TOK_W(TOK_W), .STATE_W(STATE_W),
    .INSTR_W(INSTR_W), .ENT_W(ENT_W)
  ) u_match (
    .row_i       (row),
    .meta_valid_i(meta_valid_i && meta_ready_o),
    .meta_i      (meta_data_i),
    .msg_valid_i (msg_valid_i && run),
    .msg_i       (msg_data_i),
    .take_o      (take),
    .next_o      (nxt),
    .instr_o     (ins),
    .halt_o      (halt)
  );

  orch_seq #(.STATE_W(STATE_W), .INSTR_W(INSTR_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .take_i       (take),
    .next_i       (nxt),
    .instr_i      (ins),
    .halt_i       (halt),
    .run_o        (run),
    .state_o      (cur_state),
    .instr_o      (instr_o),
    .instr_valid_o(instr_valid_o)
  );

  assign busy_o  = run;
  assign state_o = cur_state;

  // an accepted token always yields an issued word next cycle
  assert_token_emits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meta_valid_i && meta_ready_o |=> instr_valid_o);
endmodule

// File: tb/row_orchestrator_tb_top.sv
`timescale 1ns/1ps
module row_orchestrator_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [6:0]  cfg_addr_i = '0;
  logic [30:0] cfg_data_i = '0;
  logic        start_i = 1'b0;
  logic        meta_valid_i = 1'b0;
  logic [7:0]  meta_data_i = '0;
  logic        meta_ready_o;
  logic        msg_valid_i = 1'b0;
  logic [7:0]  msg_data_i = '0;
  logic [15:0] instr_o;
  logic        instr_valid_o;
  logic        busy_o;
  logic [3:0]  state_o;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  row_orchestrator dut_i (.*);

  // reference model state
  logic [30:0] m_tbl [80];
  bit          m_run;
  logic [3:0]  m_st;
  logic [15:0] m_ins;
  bit          m_vld;

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [30:0] mk(bit en, bit src, bit halt, logic [7:0] m,
                                     logic [3:0] nx, logic [15:0] ins);
    return {en, src, halt, m, nx, ins};
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    start_i = 0; cfg_we_i = 0; meta_valid_i = 0; msg_valid_i = 0;
    for (int e = 0; e < 80; e++) m_tbl[e] = '0;
    m_run = 0; m_st = 0; m_ins = 0; m_vld = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R1", busy_o, 0);
    check("R1", instr_valid_o, 0);
    check("R1", state_o, 0);
    check("R1", meta_ready_o, 0);
  endtask

  // one clock: drive at negedge, predict, compare at next negedge
  task automatic step(input bit s, input bit we, input logic [6:0] ad, input logic [30:0] dt,
                      input bit mv, input logic [7:0] md, input bit sv, input logic [7:0] sd,
                      input string tag);
    bit run0;
    string t;
    int hits, first;
    logic [30:0] e;
    start_i = s; cfg_we_i = we; cfg_addr_i = ad; cfg_data_i = dt;
    meta_valid_i = mv; meta_data_i = md; msg_valid_i = sv; msg_data_i = sd;
    #1;
    check("R4", meta_ready_o, int'(m_run && !s));
    run0 = m_run;
    t = "R3";
    if (s) begin
      m_run = 1; m_st = 0; m_vld = 0;
    end else if (m_run) begin
      hits = 0; first = -1;
      for (int k = 0; k < 4; k++) begin
        e = m_tbl[m_st*5 + k];
        if (e[30] && ((!e[29] && mv && md == e[27:20]) || (e[29] && sv && sd == e[27:20]))) begin
          hits++;
          if (first < 0) first = k;
        end
      end
      e = (first >= 0) ? m_tbl[m_st*5 + first] : m_tbl[m_st*5 + 4];
      if (first >= 0 || mv) begin
        m_st = e[19:16]; m_ins = e[15:0]; m_vld = 1;
        if (e[28]) m_run = 0;
        t = e[28] ? "R10" : (hits > 1) ? "R6" : (first >= 0 && e[29]) ? "R7" :
            (first >= 0) ? "R5" : "R8";
      end else begin
        m_vld = 1; m_ins = 0; t = "R9";
      end
    end else begin
      m_vld = 0; t = "R10";
    end
    if (we && !run0 && ad[2:0] < 5) m_tbl[ad[6:3]*5 + ad[2:0]] = dt;
    if (tag != "") t = tag;
    @(posedge clk_i);
    @(negedge clk_i);
    check(t, busy_o, m_run);
    check(t, state_o, m_st);
    check(t, instr_valid_o, m_vld);
    if (m_vld) check(t, instr_o, m_ins);
  endtask

  task automatic wr(input int st, input int sl, input logic [30:0] d, input string tag);
    step(0, 1, 7'((st << 3) | sl), d, 0, 0, 0, 0, tag);
  endtask

  task automatic tok(input bit mv, input logic [7:0] md, input bit sv, input logic [7:0] sd,
                     input string tag);
    step(0, 0, 0, 0, mv, md, sv, sd, tag);
  endtask

  initial begin
    @(negedge clk_i);
    do_reset();
    // cleared table: disabled slots, fallback to state 0 with word 0
    step(1, 0, 0, 0, 0, 0, 0, 0, "R3");
    tok(1, 8'h00, 0, 0, "R1");
    tok(1, 8'h5A, 0, 0, "R1");
    do_reset();

    // state 0
    wr(0, 0, mk(1, 0, 0, 8'h10, 4'd1, 16'h1111), "R2");
    wr(0, 1, mk(1, 0, 0, 8'h10, 4'd2, 16'h2222), "R2");
    wr(0, 2, mk(1, 1, 0, 8'h55, 4'd3, 16'h3333), "R2");
    wr(0, 4, mk(0, 0, 0, 8'h00, 4'd0, 16'h0D0D), "R2");
    // state 1
    wr(1, 0, mk(1, 0, 0, 8'h20, 4'd0, 16'hA001), "R2");
    wr(1, 1, mk(1, 1, 0, 8'h20, 4'd4, 16'hA004), "R2");
    wr(1, 3, mk(1, 0, 0, 8'h20, 4'd5, 16'hA005), "R2");
    wr(1, 4, mk(0, 0, 0, 8'h00, 4'd1, 16'hA0FF), "R2");
    // state 2: disabled slot that would match 0x30
    wr(2, 0, mk(0, 0, 0, 8'h30, 4'd9, 16'h9999), "R2");
    wr(2, 4, mk(0, 0, 0, 8'h00, 4'd2, 16'hB0B0), "R2");
    // state 3: fallback halts
    wr(3, 0, mk(1, 0, 0, 8'h44, 4'd2, 16'h4444), "R2");
    wr(3, 4, mk(0, 0, 1, 8'h00, 4'd0, 16'hDEAD), "R2");
    wr(3, 5, mk(1, 0, 0, 8'h77, 4'd8, 16'h8888), "R2");  // slot 5 ignored

    step(1, 0, 0, 0, 0, 0, 0, 0, "R3");
    tok(0, 0, 0, 0, "R9");
    tok(1, 8'h10, 0, 0, "R6");           // slots 0 and 1 both match
    tok(1, 8'h20, 1, 8'h20, "R6");       // metadata slot 0 beats message slot 1
    tok(0, 0, 1, 8'h55, "R7");
    tok(1, 8'h44, 1, 8'h99, "R5");
    tok(1, 8'h30, 0, 0, "R8");           // disabled slot, fallback
    tok(0, 0, 1, 8'h30, "R9");
    step(1, 0, 0, 0, 1, 8'h30, 0, 0, "R3");  // start wins over token
    // write during run is ignored
    wr(0, 0, mk(1, 0, 0, 8'h10, 4'd7, 16'h7777), "R2");
    tok(1, 8'h10, 0, 0, "R2");
    tok(1, 8'h20, 0, 0, "R5");
    tok(0, 0, 1, 8'h55, "R7");
    tok(1, 8'h77, 0, 0, "R10");          // state 3 fallback halts
    tok(0, 0, 0, 0, "R10");
    tok(1, 8'h10, 1, 8'h55, "R10");      // idle: token refused
    // write while idle is accepted
    wr(0, 0, mk(1, 0, 0, 8'h10, 4'd6, 16'h6666), "R2");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R3");
    tok(1, 8'h10, 0, 0, "R2");
    tok(1, 8'h01, 0, 0, "R8");

    // random mix with collisions of start, writes and tokens
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] pool [6] = '{8'h10, 8'h20, 8'h30, 8'h44, 8'h55, 8'h77};
      bit s, we, mv, sv;
      logic [7:0] md, sd;
      logic [6:0] ad;
      logic [30:0] dt;
      s  = ($urandom % 16) == 0;
      we = ($urandom % 8) == 0;
      mv = ($urandom % 3) != 0;
      sv = ($urandom % 3) == 0;
      md = pool[$urandom % 6];
      sd = pool[$urandom % 6];
      ad = 7'({$urandom % 6, 3'($urandom % 6)});
      dt = 31'($urandom);
      dt[27:20] = pool[$urandom % 6];
      dt[19:16] = 4'($urandom % 6);
      dt[28]    = ($urandom % 6) == 0;
      step(s, we, ad, dt, mv, md, sv, sd, "");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule